// File: doc/BRIEF.md
# Runtime-Programmable Sum-of-Products Array

This block is a programmable logic array whose two connection planes sit in writable storage and are filled at run time. It has M inputs, N product terms and R sum terms, and each sum term drives one output. The product plane selects, for each term and each input, the true input, the complemented input, or neither. The sum plane selects which product terms feed each output. When the planes are loaded, the outputs are a purely combinational sum-of-products of the input vector.

Loading is word-serial. A start pulse opens a sequence. Each word that follows with the valid strobe fills one row: first the N product rows, in order from term 0, and then the R sum rows, in order from output row 0. The block raises a done flag after the last sum row. It also keeps a sticky error flag that is set when a product row selects both polarities of the same input. The outputs stay at zero until a sequence completes, so no partly loaded function ever appears at the outputs.

Top module: `pla_array`

## Requirements
- R1: After reset, cfg_done and cfg_err are 0 and y_out is all zeros.
- R2: After a cfg_start, the first N cycles with cfg_valid high write product rows 0..N-1, and the next R such cycles write sum rows 0..R-1. Cycles without cfg_valid do not advance the sequence. cfg_done rises in the cycle after the clock edge that takes the last sum row.
- R3: A product row occupies cfg_data[2M-1:0] and holds a 2-bit code per input. Input x_in[p] uses bits [2p+1:2p], where bit 2p+1 selects the true input and bit 2p selects the complement. Code 10 requires x_in[p]=1, code 01 requires x_in[p]=0, and code 00 ignores the input. The first input written (x_in[M-1]) is therefore the leftmost pair.
- R4: A sum row occupies cfg_data[N-1:0]. Bit N-1-j connects product term j. Sum row k drives y_out[R-1-k], so row 0 is the most significant output. Each output is the OR of its connected terms.
- R5: A product row whose codes are all 00 evaluates to 0. A sum row with no bits set gives 0.
- R6: Writing a product row that contains code 11 for any input sets cfg_err one cycle later. cfg_err then stays set until the next cfg_start, and a row holding code 11 never asserts its term.
- R7: y_out is all zeros whenever cfg_done is 0, and that includes the time during loading.
- R8: cfg_start clears cfg_done and cfg_err on the next edge and restarts at product row 0. A word presented with cfg_valid in the same cycle as cfg_start is discarded: it is not written, it does not count, and it cannot set cfg_err.
- R9: cfg_valid while no sequence is open (after cfg_done) changes neither plane nor any flag.
- R10: y_out follows x_in with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the programming logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | Opens a new loading sequence |
| cfg_valid | input | 1 | cfg_data carries one row this cycle |
| cfg_data | input | max(2M,N) | Row word: product row in [2M-1:0], sum row in [N-1:0] |
| cfg_done | output | 1 | All rows of the current sequence are loaded |
| cfg_err | output | 1 | A product row of this sequence had a both-polarity code |
| x_in | input | M | Input vector |
| y_out | output | R | Sum-of-products outputs, row 0 at the MSB |

## Verification
The start strobe and the row strobe can fall in the same cycle, and the same can happen to the error capture and a restart. The bench provokes both in the middle of a sequence: it presents a word with code 11 in every position together with cfg_start. It then judges the outcome at the ports. cfg_err must stay low, cfg_done must not rise until a full N+R words have followed, and the resulting function must match the arithmetic half-adder sum and carry over all input pairs.

// File: rtl/pla_pkg.sv
package pla_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_AND  = 2'd1,
    PH_OR   = 2'd2
  } pla_phase_e;
endpackage

// File: rtl/pla_loader.sv
module pla_loader
  import pla_pkg::*;
#(
  parameter int N  = 3,
  parameter int R  = 2,
  parameter int RW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          valid,
  input  logic          row_illegal,
  output logic          and_we,
  output logic          or_we,
  output logic [RW-1:0] row,
  output logic          done,
  output logic          err
);
  localparam logic [RW-1:0] LAST_AND = RW'(N - 1);
  localparam logic [RW-1:0] LAST_OR  = RW'(R - 1);

  pla_phase_e    ph_q, ph_d;
  logic [RW-1:0] row_q, row_d;
  logic          done_q, done_d;
  logic          err_q, err_d;

  always_comb begin
    ph_d   = ph_q;
    row_d  = row_q;
    done_d = done_q;
    err_d  = err_q;
    and_we = 1'b0;
    or_we  = 1'b0;
    if (start) begin
      ph_d   = PH_AND;
      row_d  = '0;
      done_d = 1'b0;
      err_d  = 1'b0;
    end else if (valid) begin
      case (ph_q)
        PH_AND: begin
          and_we = 1'b1;
          if (row_illegal) err_d = 1'b1;
          if (row_q == LAST_AND) begin
            ph_d  = PH_OR;
            row_d = '0;
          end else begin
            row_d = row_q + 1'b1;
          end
        end
        PH_OR: begin
          or_we = 1'b1;
          if (row_q == LAST_OR) begin
            ph_d   = PH_IDLE;
            row_d  = '0;
            done_d = 1'b1;
          end else begin
            row_d = row_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      row_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      row_q  <= row_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign row  = row_q;
  assign done = done_q;
  assign err  = err_q;

  assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && !err));

  assert_done_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(ph_q == PH_OR && valid && !start && row_q == LAST_OR));

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> err);

  assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(and_we && row_illegal));

  assert_idle_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE) |-> (!and_we && !or_we));
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int M  = 2,
  parameter int N  = 3,
  parameter int RW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [RW-1:0]  row,
  input  logic [2*M-1:0] wdata,
  input  logic [M-1:0]   x,
  output logic           wr_illegal,
  output logic [N-1:0]   terms
);
  localparam int AW = 2 * M;

  logic [AW-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[row] <= wdata;
  end

  always_comb begin
    wr_illegal = 1'b0;
    for (int p = 0; p < M; p++) begin
      if (wdata[2*p+1] && wdata[2*p]) wr_illegal = 1'b1;
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_term
    logic match;
    logic used;
    always_comb begin
      match = 1'b1;
      used  = 1'b0;
      for (int p = 0; p < M; p++) begin
        if (mem[j][2*p+1] || mem[j][2*p]) used = 1'b1;
        if (mem[j][2*p+1] && !x[p]) match = 1'b0;
        if (mem[j][2*p] && x[p]) match = 1'b0;
      end
    end
    assign terms[N-1-j] = match & used;
  end

  assert_row_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (int'(row) < N));
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N  = 3,
  parameter int R  = 2,
  parameter int RW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [RW-1:0] row,
  input  logic [N-1:0]  wdata,
  input  logic [N-1:0]  terms,
  input  logic          en,
  output logic [R-1:0]  y
);
  logic [N-1:0] mem [R];
  logic [R-1:0] sum;

  always_ff @(posedge clk) begin
    if (we) mem[row] <= wdata;
  end

  for (genvar k = 0; k < R; k++) begin : g_sum
    assign sum[R-1-k] = |(mem[k] & terms);
  end

  assign y = en ? sum : '0;

  assert_row_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (int'(row) < R));

  assert_no_write_when_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> !we);
endmodule

// File: rtl/pla_array.sv
module pla_array #(
  parameter int M = 4,
  parameter int N = 8,
  parameter int R = 4,
  localparam int CW    = (2 * M > N) ? 2 * M : N,
  localparam int MAXNR = (N > R) ? N : R,
  localparam int RW    = (MAXNR > 1) ? $clog2(MAXNR) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_start,
  input  logic          cfg_valid,
  input  logic [CW-1:0] cfg_data,
  output logic          cfg_done,
  output logic          cfg_err,
  input  logic [M-1:0]  x_in,
  output logic [R-1:0]  y_out
);
  logic          and_we;
  logic          or_we;
  logic          row_illegal;
  logic [RW-1:0] row;
  logic [N-1:0]  terms;

  pla_loader #(.N(N), .R(R), .RW(RW)) u_loader (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (cfg_start),
    .valid       (cfg_valid),
    .row_illegal (row_illegal),
    .and_we      (and_we),
    .or_we       (or_we),
    .row         (row),
    .done        (cfg_done),
    .err         (cfg_err)
  );

  pla_and_plane #(.M(M), .N(N), .RW(RW)) u_and (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (and_we),
    .row        (row),
    .wdata      (cfg_data[2*M-1:0]),
    .x          (x_in),
    .wr_illegal (row_illegal),
    .terms      (terms)
  );

  pla_or_plane #(.N(N), .R(R), .RW(RW)) u_or (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (or_we),
    .row   (row),
    .wdata (cfg_data[N-1:0]),
    .terms (terms),
    .en    (cfg_done),
    .y     (y_out)
  );

  assert_single_plane_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(and_we && or_we));

  assert_quiet_until_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_done && !$past(cfg_done)) |-> (y_out == '0));
endmodule

// File: tb/sim_pla_array.sv
module sim_pla_array;
  localparam int CLK_PERIOD = 10;
  localparam int M = 2;
  localparam int N = 3;
  localparam int R = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_start, cfg_valid;
  logic [3:0] cfg_data;
  logic       cfg_done, cfg_err;
  logic [1:0] x_in;
  logic [1:0] y_out;

  int n_chk = 0;
  int n_bad = 0;

  logic [3:0] ar [N];
  logic [2:0] orr [R];

  always #(CLK_PERIOD / 2) clk = ~clk;

  pla_array #(.M(M), .N(N), .R(R)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_valid(cfg_valid),
    .cfg_data(cfg_data), .cfg_done(cfg_done), .cfg_err(cfg_err),
    .x_in(x_in), .y_out(y_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] model(input logic [1:0] x);
    logic [2:0] t;
    logic [1:0] y;
    for (int j = 0; j < N; j++) begin
      logic hit;
      hit = (ar[j] != 4'b0000);
      for (int p = 0; p < M; p++) begin
        logic [1:0] c;
        c = ar[j][2*p +: 2];
        if (c == 2'b11) hit = 1'b0;
        if (c == 2'b10 && !x[p]) hit = 1'b0;
        if (c == 2'b01 && x[p]) hit = 1'b0;
      end
      t[N-1-j] = hit;
    end
    for (int k = 0; k < R; k++) y[R-1-k] = |(orr[k] & t);
    return y;
  endfunction

  task automatic send(input logic [3:0] d);
    @(negedge clk);
    cfg_valid = 1'b1;
    cfg_data  = d;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
  endtask

  task automatic load_all();
    pulse_start();
    for (int j = 0; j < N; j++) send(ar[j]);
    for (int k = 0; k < R; k++) send({1'b0, orr[k]});
  endtask

  task automatic half_adder();
    ar[0] = 4'b1001; ar[1] = 4'b0110; ar[2] = 4'b1010;
    orr[0] = 3'b001; orr[1] = 3'b110;
  endtask

  task automatic sweep_ha(input string tag);
    for (int v = 0; v < 4; v++) begin
      int a, b, e;
      x_in = 2'(v);
      #1;
      a = v >> 1;
      b = v & 1;
      e = ((a & b) << 1) | (a ^ b);
      chk(y_out == 2'(e), tag, int'(y_out), e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    rst_n = 1'b0; cfg_start = 1'b0; cfg_valid = 1'b0; cfg_data = '0; x_in = 2'b11;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cfg_done == 1'b0, "R1 done after reset", cfg_done, 0);
    chk(cfg_err == 1'b0, "R1 err after reset", cfg_err, 0);
    chk(y_out == 2'b00, "R1 y after reset", y_out, 0);

    // R2 / R7: load the half adder, checking quiet outputs and done timing
    half_adder();
    pulse_start();
    for (int j = 0; j < N; j++) begin
      send(ar[j]);
      chk(cfg_done == 1'b0, "R2 done during product rows", cfg_done, 0);
      chk(y_out == 2'b00, "R7 y zero while loading", y_out, 0);
    end
    send({1'b0, orr[0]});
    @(negedge clk);
    chk(cfg_done == 1'b0, "R2 idle cycle does not advance", cfg_done, 0);
    send({1'b0, orr[1]});
    chk(cfg_done == 1'b1, "R2 done after last sum row", cfg_done, 1);
    chk(cfg_err == 1'b0, "R6 no error on legal rows", cfg_err, 0);
    sweep_ha("R4 R10 half adder sum/carry");

    // R9: words after completion are ignored
    send(4'b1111);
    send(4'b0000);
    chk(cfg_done == 1'b1, "R9 done kept", cfg_done, 1);
    chk(cfg_err == 1'b0, "R9 err untouched", cfg_err, 0);
    sweep_ha("R9 function unchanged");

    // R3 R4 R5: pseudo-random legal planes, exhaustive over inputs
    lf = 16'hACE1;
    for (int c = 0; c < 24; c++) begin
      for (int j = 0; j < N; j++) begin
        for (int p = 0; p < M; p++) begin
          lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
          lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
          ar[j][2*p +: 2] = (lf[1:0] == 2'b11) ? 2'b00 : lf[1:0];
        end
      end
      for (int k = 0; k < R; k++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        orr[k] = lf[2:0];
      end
      if (c == 0) begin
        ar[1] = 4'b0000; orr[0] = 3'b010; orr[1] = 3'b000;
      end
      load_all();
      for (int v = 0; v < 4; v++) begin
        x_in = 2'(v);
        #1;
        chk(y_out == model(2'(v)), (c == 0) ? "R5 empty row/term" : "R3 R4 random plane",
            int'(y_out), int'(model(2'(v))));
      end
    end

    // R6: both-polarity code in product row 1
    ar[0] = 4'b1000; ar[1] = 4'b1100; ar[2] = 4'b0010;
    orr[0] = 3'b010; orr[1] = 3'b111;
    pulse_start();
    send(ar[0]);
    chk(cfg_err == 1'b0, "R6 err before bad row", cfg_err, 0);
    send(ar[1]);
    chk(cfg_err == 1'b1, "R6 err after bad row", cfg_err, 1);
    send(ar[2]);
    send({1'b0, orr[0]});
    send({1'b0, orr[1]});
    chk(cfg_err == 1'b1, "R6 err sticky", cfg_err, 1);
    chk(cfg_done == 1'b1, "R6 done still reached", cfg_done, 1);
    for (int v = 0; v < 4; v++) begin
      x_in = 2'(v);
      #1;
      chk(y_out == model(2'(v)), "R6 bad row term inactive", int'(y_out), int'(model(2'(v))));
    end
    pulse_start();
    chk(cfg_err == 1'b0, "R8 start clears err", cfg_err, 0);
    chk(cfg_done == 1'b0, "R8 start clears done", cfg_done, 0);
    chk(y_out == 2'b00, "R7 y zero after restart", y_out, 0);

    // R8: start collides with a valid word mid-sequence
    half_adder();
    send(ar[0]);
    send(ar[1]);
    @(negedge clk);
    cfg_start = 1'b1; cfg_valid = 1'b1; cfg_data = 4'b1111;
    @(negedge clk);
    cfg_start = 1'b0; cfg_valid = 1'b0;
    chk(cfg_err == 1'b0, "R8 collided word sets no err", cfg_err, 0);
    for (int j = 0; j < N; j++) send(ar[j]);
    send({1'b0, orr[0]});
    chk(cfg_done == 1'b0, "R8 collided word not counted", cfg_done, 0);
    send({1'b0, orr[1]});
    chk(cfg_done == 1'b1, "R8 done after full sequence", cfg_done, 1);
    sweep_ha("R8 function after collision");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule